// File: doc/BRIEF.md
# Backplane Trigger-Line Synchronization Router

This block connects three timing signals of a data-acquisition board to a shared bidirectional trigger bus of eight lines. The signals are a sample timebase, an A/D start trigger and an A/D conversion strobe. One board on the bus is the timing master. It places each enabled signal on a bus line chosen by configuration. The other boards are receivers. Each receiver picks its signals from the bus lines chosen in its own configuration and uses them in place of its local sources.

Every signal has an enable bit and a 3-bit line number. A line is driven only when all three of these hold:
- the board is master,
- exactly one enabled signal claims the line,
- so no routing conflict exists on that line.

A line claimed by two or more enabled signals is reported, and its driver is held off. A received trigger or conversion strobe is resynchronized through two flops before use. The received timebase is steered to the output combinationally, with a select flag for a downstream clock multiplexer. A disabled signal always falls back to its local source.

Top module: `trig_bus_router`

## Requirements
- R1: While rst_ni is low, trig_o and conv_o read 0 whenever they are taken from the bus (receiver mode, signal enabled). This holds whatever the bus lines carry.
- R2: In master mode, an enabled signal whose line has no conflict sets bus_oe_o at that line to 1. It also places the signal's local value on bus_out_o at that line, in the same cycle, with no clock edge needed.
- R3: For any line, bus_oe_o and bus_out_o read 0 in three cases: no enabled signal selects the line, the board is in receiver mode (master_i = 0), or the line has a conflict.
- R4: When two or more enabled signals select the same line, conflict_line_o sets that line's bit and conflict_o reads 1. That line's output enable is 0. Lines without a conflict keep being driven normally.
- R5: A disabled signal takes no part in conflict detection or in driving, whatever line number it carries.
- R6: In receiver mode with the timebase enabled, tb_sel_o reads 1 and tb_o follows the selected bus line combinationally. Otherwise tb_sel_o reads 0 and tb_o follows loc_tb_i.
- R7: In receiver mode with the trigger (or conversion strobe) enabled, trig_o (or conv_o) shows the selected bus line's value. That value is the one sampled two rising clock edges earlier: a change first appears after the second rising edge.
- R8: In master mode, trig_o, conv_o and tb_o follow loc_trig_i, loc_conv_i and loc_tb_i combinationally. The same holds in either mode for any signal whose enable bit is 0.
- R9: Encoding. Signal index 0 is the timebase, 1 the trigger and 2 the conversion strobe. Bit s of cfg_en_i enables signal s. cfg_sel_i bits [2:0], [5:3] and [8:6] hold the line numbers of signals 0, 1 and 2, and line number k addresses bit k of the bus vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| master_i | input | 1 | 1: drive the bus, 0: receive from it |
| cfg_en_i | input | 3 | Per-signal enable (bit 0 timebase, 1 trigger, 2 conversion) |
| cfg_sel_i | input | 9 | Per-signal 3-bit line number, signal 0 in bits [2:0] |
| loc_tb_i | input | 1 | Local timebase |
| loc_trig_i | input | 1 | Local A/D trigger |
| loc_conv_i | input | 1 | Local conversion strobe |
| bus_in_i | input | 8 | Sampled trigger-bus lines |
| bus_out_o | output | 8 | Values driven onto the bus lines |
| bus_oe_o | output | 8 | Per-line output enable (0 = high impedance) |
| tb_sel_o | output | 1 | 1 when the bus timebase replaces the local one |
| tb_o | output | 1 | Timebase in use |
| trig_o | output | 1 | Digital trigger in use |
| conv_o | output | 1 | Conversion strobe in use |
| conflict_o | output | 1 | Any line has a routing conflict |
| conflict_line_o | output | 8 | Per-line conflict flags |

## Verification
All routing and conflict state is combinational, so a mistake in line decoding, conflict counting or mode gating shows on bus_oe_o, bus_out_o or conflict_line_o in the same cycle as the configuration that provokes it. A fault in the receive path shows on trig_o or conv_o within two rising edges, as a wrong value or as an early or late edge. The mode and enable muxes are checked by driving the local and bus sources with different values. A wrong choice of source then changes the output at once.

// File: rtl/trig_route_pkg.sv
package trig_route_pkg;
  localparam int N_SIG     = 3;
  localparam int SIG_TB    = 0;
  localparam int SIG_TRIG  = 1;
  localparam int SIG_CONV  = 2;
endpackage

// File: rtl/trig_conflict_det.sv
module trig_conflict_det #(
  parameter int N_LINES = 8,
  parameter int N_SIG   = 3,
  parameter int LSEL_W  = $clog2(N_LINES)
) (
  input  logic [N_SIG-1:0]        en_i,
  input  logic [N_SIG*LSEL_W-1:0] sel_i,
  output logic [N_LINES-1:0]      hit_o,
  output logic [N_LINES-1:0]      conflict_o
);
  localparam int CNT_W = $clog2(N_SIG + 1);

  for (genvar l = 0; l < N_LINES; l++) begin : g_line
    logic [CNT_W-1:0] cnt;
    always_comb begin
      cnt = '0;
      for (int s = 0; s < N_SIG; s++) begin
        if (en_i[s] && (sel_i[s*LSEL_W +: LSEL_W] == LSEL_W'(l)))
          cnt = cnt + CNT_W'(1);
      end
    end
    assign hit_o[l]      = (cnt != '0);
    assign conflict_o[l] = (cnt > CNT_W'(1));
  end
endmodule

// File: rtl/trig_line_drv.sv
module trig_line_drv #(
  parameter int N_LINES = 8,
  parameter int N_SIG   = 3,
  parameter int LSEL_W  = $clog2(N_LINES)
) (
  input  logic                    master_i,
  input  logic [N_SIG-1:0]        en_i,
  input  logic [N_SIG*LSEL_W-1:0] sel_i,
  input  logic [N_SIG-1:0]        src_i,
  input  logic [N_LINES-1:0]      hit_i,
  input  logic [N_LINES-1:0]      conflict_i,
  output logic [N_LINES-1:0]      oe_o,
  output logic [N_LINES-1:0]      out_o
);
  for (genvar l = 0; l < N_LINES; l++) begin : g_line
    logic val;
    always_comb begin
      val = 1'b0;
      for (int s = 0; s < N_SIG; s++) begin
        if (en_i[s] && (sel_i[s*LSEL_W +: LSEL_W] == LSEL_W'(l)))
          val = val | src_i[s];
      end
    end
    assign oe_o[l]  = master_i & hit_i[l] & ~conflict_i[l];
    assign out_o[l] = oe_o[l] & val;  // quiet line when not driving
  end
endmodule

// File: rtl/trig_rx_sync.sv
module trig_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr <= '0;
    else         sr <= {sr[STAGES-2:0], d_i};
  end

  assign q_o = sr[STAGES-1];
endmodule

// File: rtl/trig_bus_router.sv
module trig_bus_router
  import trig_route_pkg::*;
#(
  parameter int N_LINES     = 8,
  parameter int SYNC_STAGES = 2,
  localparam int LSEL_W     = $clog2(N_LINES)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    master_i,
  input  logic [N_SIG-1:0]        cfg_en_i,
  input  logic [N_SIG*LSEL_W-1:0] cfg_sel_i,
  input  logic                    loc_tb_i,
  input  logic                    loc_trig_i,
  input  logic                    loc_conv_i,
  input  logic [N_LINES-1:0]      bus_in_i,
  output logic [N_LINES-1:0]      bus_out_o,
  output logic [N_LINES-1:0]      bus_oe_o,
  output logic                    tb_sel_o,
  output logic                    tb_o,
  output logic                    trig_o,
  output logic                    conv_o,
  output logic                    conflict_o,
  output logic [N_LINES-1:0]      conflict_line_o
);
  logic [N_SIG-1:0]   loc_src, rx_raw, rx_use, rx_val;
  logic [N_LINES-1:0] hit;

  assign loc_src = {loc_conv_i, loc_trig_i, loc_tb_i};

  trig_conflict_det #(.N_LINES(N_LINES), .N_SIG(N_SIG), .LSEL_W(LSEL_W)) u_det (
    .en_i       (cfg_en_i),
    .sel_i      (cfg_sel_i),
    .hit_o      (hit),
    .conflict_o (conflict_line_o)
  );

  trig_line_drv #(.N_LINES(N_LINES), .N_SIG(N_SIG), .LSEL_W(LSEL_W)) u_drv (
    .master_i   (master_i),
    .en_i       (cfg_en_i),
    .sel_i      (cfg_sel_i),
    .src_i      (loc_src),
    .hit_i      (hit),
    .conflict_i (conflict_line_o),
    .oe_o       (bus_oe_o),
    .out_o      (bus_out_o)
  );

  assign conflict_o = |conflict_line_o;

  for (genvar s = 0; s < N_SIG; s++) begin : g_rx
    assign rx_raw[s] = bus_in_i[cfg_sel_i[s*LSEL_W +: LSEL_W]];
    assign rx_use[s] = ~master_i & cfg_en_i[s];
    if (s == SIG_TB) begin : g_clk
      // timebase goes straight to the clock-select mux
      assign rx_val[s] = rx_raw[s];
    end else begin : g_sync
      trig_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (rx_raw[s]),
        .q_o    (rx_val[s])
      );
    end
  end

  assign tb_sel_o = rx_use[SIG_TB];
  assign tb_o     = rx_use[SIG_TB]   ? rx_val[SIG_TB]   : loc_tb_i;
  assign trig_o   = rx_use[SIG_TRIG] ? rx_val[SIG_TRIG] : loc_trig_i;
  assign conv_o   = rx_use[SIG_CONV] ? rx_val[SIG_CONV] : loc_conv_i;
endmodule

// File: rtl/trig_bus_router_chk.sv
module trig_bus_router_chk #(
  parameter int N_LINES = 8,
  localparam int LSEL_W = $clog2(N_LINES)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  master_i,
  input logic [2:0]            cfg_en_i,
  input logic [3*LSEL_W-1:0]   cfg_sel_i,
  input logic                  loc_tb_i,
  input logic                  loc_trig_i,
  input logic [N_LINES-1:0]    bus_in_i,
  input logic [N_LINES-1:0]    bus_out_o,
  input logic [N_LINES-1:0]    bus_oe_o,
  input logic                  tb_sel_o,
  input logic                  tb_o,
  input logic                  trig_o,
  input logic [N_LINES-1:0]    conflict_line_o
);
  logic [1:0] up_cnt;
  logic       trig_line;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            up_cnt <= '0;
    else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
  end

  assign trig_line = bus_in_i[cfg_sel_i[2*LSEL_W-1:LSEL_W]];

  // R3: receiver never drives
  p_oe_master_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_oe_o != '0) |-> master_i);

  // R4: conflicting line stays undriven
  p_oe_no_conflict_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_oe_o & conflict_line_o) == '0);

  // R3: undriven line carries 0
  p_out_gated_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_out_o & ~bus_oe_o) == '0);

  // R6: local timebase when not selecting the bus
  p_tb_local_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tb_sel_o |-> (tb_o == loc_tb_i));

  // R7: two-edge receive latency with steady routing
  p_trig_latency_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_cnt >= 2'd2 && !master_i && cfg_en_i[1] &&
     $past(cfg_sel_i, 1) == cfg_sel_i && $past(cfg_sel_i, 2) == cfg_sel_i)
    |-> (trig_o == $past(trig_line, 2)));

  // R8: master uses local trigger
  p_trig_local_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_i |-> (trig_o == loc_trig_i));
endmodule

bind trig_bus_router trig_bus_router_chk #(.N_LINES(N_LINES)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .master_i        (master_i),
  .cfg_en_i        (cfg_en_i),
  .cfg_sel_i       (cfg_sel_i),
  .loc_tb_i        (loc_tb_i),
  .loc_trig_i      (loc_trig_i),
  .bus_in_i        (bus_in_i),
  .bus_out_o       (bus_out_o),
  .bus_oe_o        (bus_oe_o),
  .tb_sel_o        (tb_sel_o),
  .tb_o            (tb_o),
  .trig_o          (trig_o),
  .conflict_line_o (conflict_line_o)
);

// File: tb/sim_trig_bus_router.sv
`timescale 1ns/1ps
module sim_trig_bus_router;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       master;
  logic [2:0] en;
  logic [8:0] sel;
  logic       ltb, ltrig, lconv;
  logic [7:0] bin;
  logic [7:0] bout, boe, cline;
  logic       tbsel, tb, trig, conv, conf;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  trig_bus_router u0 (
    .clk_i(clk), .rst_ni(rst_n), .master_i(master), .cfg_en_i(en), .cfg_sel_i(sel),
    .loc_tb_i(ltb), .loc_trig_i(ltrig), .loc_conv_i(lconv), .bus_in_i(bin),
    .bus_out_o(bout), .bus_oe_o(boe), .tb_sel_o(tbsel), .tb_o(tb), .trig_o(trig),
    .conv_o(conv), .conflict_o(conf), .conflict_line_o(cline)
  );

  always #5 clk = ~clk;

  // reference two-edge receive pipes
  logic [1:0] p_trig, p_conv;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_trig <= '0;
      p_conv <= '0;
    end else begin
      p_trig <= {p_trig[0], bin[sel[5:3]]};
      p_conv <= {p_conv[0], bin[sel[8:6]]};
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] f_conf(logic [2:0] e, logic [8:0] s);
    logic [7:0] r = '0;
    for (int l = 0; l < 8; l++) begin
      int c = 0;
      for (int k = 0; k < 3; k++)
        if (e[k] && s[k*3 +: 3] == 3'(l)) c++;
      r[l] = (c > 1);
    end
    return r;
  endfunction

  function automatic logic [7:0] f_oe(logic m, logic [2:0] e, logic [8:0] s);
    logic [7:0] h = '0;
    for (int k = 0; k < 3; k++)
      if (e[k]) h[s[k*3 +: 3]] = 1'b1;
    return m ? (h & ~f_conf(e, s)) : 8'h00;
  endfunction

  function automatic logic [7:0] f_out(logic m, logic [2:0] e, logic [8:0] s, logic [2:0] src);
    logic [7:0] r = '0;
    for (int k = 0; k < 3; k++)
      if (e[k]) r[s[k*3 +: 3]] = r[s[k*3 +: 3]] | src[k];
    return r & f_oe(m, e, s);
  endfunction

  task automatic check_all(string tag);
    chk({tag, " R4 conflict_line"}, 32'(cline), 32'(f_conf(en, sel)));
    chk({tag, " R4 conflict_o"}, 32'(conf), 32'(|f_conf(en, sel)));
    chk({tag, " R2 bus_oe"}, 32'(boe), 32'(f_oe(master, en, sel)));
    chk({tag, " R3 bus_out"}, 32'(bout), 32'(f_out(master, en, sel, {lconv, ltrig, ltb})));
    chk({tag, " R6 tb_sel"}, 32'(tbsel), 32'(!master && en[0]));
    chk({tag, " R6 tb"}, 32'(tb), 32'((!master && en[0]) ? bin[sel[2:0]] : ltb));
    chk({tag, " R7 trig"}, 32'(trig), 32'((!master && en[1]) ? p_trig[1] : ltrig));
    chk({tag, " R7 conv"}, 32'(conv), 32'((!master && en[2]) ? p_conv[1] : lconv));
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    master = 1'b0; en = 3'b110; sel = {3'd5, 3'd2, 3'd0};
    ltb = 1'b1; ltrig = 1'b1; lconv = 1'b1; bin = 8'hFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 trig in reset", 32'(trig), 0);
    chk("R1 conv in reset", 32'(conv), 0);
    rst_n = 1'b1;

    // R7: latency of two edges
    bin = 8'h00;
    repeat (3) @(negedge clk);
    bin[2] = 1'b1;
    @(negedge clk);
    chk("R7 trig after one edge", 32'(trig), 0);
    @(negedge clk);
    chk("R7 trig after two edges", 32'(trig), 1);
    chk("R7 conv unaffected", 32'(conv), 0);

    // R6: bus timebase, combinational
    en = 3'b001; sel[2:0] = 3'd6; bin = 8'h40; ltb = 1'b0; #1;
    chk("R6 tb_sel", 32'(tbsel), 1);
    chk("R6 tb from line 6", 32'(tb), 1);
    bin = 8'h00; #1;
    chk("R6 tb follows line", 32'(tb), 0);
    @(negedge clk);

    // R2/R9: master drive
    master = 1'b1; en = 3'b111; sel = {3'd7, 3'd3, 3'd0};
    ltb = 1'b1; ltrig = 1'b0; lconv = 1'b1; #1;
    chk("R2 R9 oe", 32'(boe), 32'h89);
    chk("R2 R9 out", 32'(bout), 32'h81);
    chk("R8 master trig local", 32'(trig), 0);
    chk("R8 master conv local", 32'(conv), 1);
    chk("R8 master tb local", 32'(tb), 1);

    // R4: conflict on line 4
    sel = {3'd1, 3'd4, 3'd4}; ltrig = 1'b1; #1;
    chk("R4 conflict_line", 32'(cline), 32'h10);
    chk("R4 conflict_o", 32'(conf), 1);
    chk("R4 oe", 32'(boe), 32'h02);
    chk("R4 out", 32'(bout), 32'h02);

    // R5: disabled signal ignored
    en = 3'b101; #1;
    chk("R5 no conflict", 32'(cline), 0);
    chk("R5 oe", 32'(boe), 32'h12);

    // R3: receiver drives nothing
    master = 1'b0; en = 3'b111; sel = {3'd1, 3'd2, 3'd3}; #1;
    chk("R3 receiver oe", 32'(boe), 0);
    chk("R3 receiver out", 32'(bout), 0);

    // R8: disabled in receiver mode
    en = 3'b000; ltrig = 1'b0; lconv = 1'b1; ltb = 1'b1; bin = 8'hFF; #1;
    chk("R8 disabled trig local", 32'(trig), 0);
    chk("R8 disabled conv local", 32'(conv), 1);
    chk("R8 disabled tb local", 32'(tb), 1);

    // random mix
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      master = 1'($urandom);
      en     = 3'($urandom);
      if (i % 4 != 0) sel = 9'($urandom);
      ltb = 1'($urandom); ltrig = 1'($urandom); lconv = 1'($urandom);
      bin = 8'($urandom);
      #1;
      check_all("rand");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule